// File: doc/BRIEF.md
# Indexed Draw Vertex Cache

This block turns a draw command into a stream of shaded vertices. For every draw position it forms a vertex number, either by reading an element of an index array (indexed draws) or by adding a start offset to the position (non-indexed draws). Indexed draws go through a small post-transform cache of recently shaded vertices. A vertex found in the cache is sent out again without a second shading pass. A vertex not found is sent to an external shader over a request/response handshake. The shaded result is then placed in the cache slot picked by a circular replacement pointer.

The index array sits behind a synchronous read port that returns data one cycle after the read enable. Elements are 8 or 16 bits wide, chosen per draw. Shaded vertices leave in draw-position order on a valid/ready stream, one beat per position. The consumer may hold `out_ready` low for any number of cycles. While it does, the beat on the port stays unchanged and the engine fetches nothing further. The shader request also follows valid/ready rules: `shd_req_vid` holds until it is accepted. A single-cycle `done` pulse closes each draw. A single-cycle `err` pulse marks an index that cannot be cached.

Top module: `vtx_reuse_cache`

## Requirements
- R1: While reset is applied and directly after it, `out_valid`, `shd_req_valid`, `idx_rd_en`, `done` and `err` are all low.
- R2: Each accepted `start` empties the cache and returns the replacement pointer to slot 0. A draw therefore never hits on a vertex shaded by an earlier draw.
- R3: When `cfg_indexed` is 0, the vertex number is (position + `cfg_offset`) modulo 2^16. `out_hit` is 0 and every position is shaded. No index read is issued and no error is raised, even for vertex number 0xFFFF.
- R4: When `cfg_indexed` is 1 and `cfg_wide` is 1, the vertex number is the 16-bit word at `idx_rd_addr` = position. When `cfg_wide` is 0, the word at position/2 is read: an even position takes bits 7:0 and an odd position takes bits 15:8, zero-extended.
- R5: An indexed lookup compares the vertex number with all 32 stored tags at once. On a match, the stored data goes out with `out_hit` = 1 and no shader request is made.
- R6: On an indexed miss, exactly one shader request carries the vertex number. The accepted response is sent out with `out_hit` = 0 and written into the slot under the pointer, which then advances modulo 32. The 33rd distinct vertex of a draw therefore evicts the first.
- R7: In an indexed draw, the vertex number 0xFFFF raises a one-cycle `err` pulse. That position is still shaded and sent out with `out_hit` = 0, but it is never looked up or stored.
- R8: Exactly `cfg_count` beats leave per draw, in position order. While `out_valid` is high and `out_ready` is low, `out_vid`, `out_data` and `out_hit` stay stable.
- R9: `done` pulses for one cycle, in the cycle after the last beat is accepted. With `cfg_count` = 0, it pulses in the cycle after `start` and no beat is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a draw when the block is idle |
| cfg_indexed | input | 1 | 1 = vertex numbers from index array, 0 = position plus offset |
| cfg_wide | input | 1 | Index element size: 1 = 16-bit, 0 = 8-bit |
| cfg_count | input | CW | Number of draw positions |
| cfg_offset | input | VW | Start offset for non-indexed draws |
| idx_rd_en | output | 1 | Index memory read strobe |
| idx_rd_addr | output | VW | Index memory word address |
| idx_rd_data | input | VW | Index memory word, one cycle after the strobe |
| shd_req_valid | output | 1 | Shader request valid |
| shd_req_ready | input | 1 | Shader request ready |
| shd_req_vid | output | VW | Vertex number to shade |
| shd_rsp_valid | input | 1 | Shader response valid |
| shd_rsp_ready | output | 1 | Shader response ready |
| shd_rsp_data | input | DW | Shaded vertex data |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat ready |
| out_vid | output | VW | Vertex number of the beat |
| out_data | output | DW | Shaded data of the beat |
| out_hit | output | 1 | Beat was served from the cache |
| done | output | 1 | One-cycle end-of-draw pulse |
| err | output | 1 | One-cycle pulse for an uncacheable index |

## Verification
Acceptance of an output beat and the index read for the next position fall in the same cycle: the read strobe and address for position p+1 depend on `out_ready` during the handshake of position p. The bench provokes this by running draws with `out_ready` held high and with `out_ready` toggling, in both element widths. In 8-bit mode the byte lane depends on position parity, so a read issued for the wrong position, or issued while the beat is stalled, shows up as a wrong vertex number. Every beat is compared with a reference built from the requirements, covering vertex number, data and hit flag, and the number of shader requests per draw is compared as well.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOOK,
    ST_REQ,
    ST_RSP,
    ST_EMIT
  } vc_state_e;
endpackage

// File: rtl/vc_index_sel.sv
// Forms index-memory addresses and vertex numbers for both draw kinds.
module vc_index_sel #(
  parameter int VW = 16,
  parameter int CW = 16
) (
  input  logic          indexed,
  input  logic          wide,
  input  logic [CW-1:0] rd_pos,
  input  logic [CW-1:0] cur_pos,
  input  logic [VW-1:0] offset,
  input  logic [VW-1:0] rd_data,
  output logic [VW-1:0] rd_addr,
  output logic [VW-1:0] vid
);
  localparam int HW = VW / 2;

  logic [VW-1:0] rd_pos_w;
  logic [VW-1:0] cur_pos_w;
  logic [VW-1:0] narrow_v;

  assign rd_pos_w  = VW'(rd_pos);
  assign cur_pos_w = VW'(cur_pos);
  // 8-bit elements: two per word, even position in the low half
  assign rd_addr   = wide ? rd_pos_w : (rd_pos_w >> 1);
  assign narrow_v  = cur_pos[0] ? {{(VW-HW){1'b0}}, rd_data[VW-1:HW]}
                                : {{(VW-HW){1'b0}}, rd_data[HW-1:0]};

  always_comb begin
    if (!indexed)  vid = cur_pos_w + offset;
    else if (wide) vid = rd_data;
    else           vid = narrow_v;
  end
endmodule

// File: rtl/vc_tag_store.sv
// Fully associative store with parallel compare and circular fill pointer.
module vc_tag_store #(
  parameter int NE = 32,
  parameter int VW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inval,
  input  logic          lk_en,
  input  logic [VW-1:0] lk_key,
  input  logic          wr_en,
  input  logic [VW-1:0] wr_tag,
  input  logic [DW-1:0] wr_data,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data
);
  localparam int PW = (NE > 1) ? $clog2(NE) : 1;
  localparam logic [PW-1:0] LAST = PW'(NE - 1);

  logic [PW-1:0] ptr_q;
  logic [NE-1:0] match;
  logic [DW-1:0] sel_chain [NE+1];

  assign sel_chain[0] = '0;

  for (genvar g = 0; g < NE; g++) begin : g_ent
    logic [VW-1:0] tag_r;
    logic [DW-1:0] dat_r;
    logic          fill;

    assign fill     = wr_en && (ptr_q == PW'(g));
    assign match[g] = lk_en && (tag_r == lk_key);
    // tags are unique, so an OR of the selected entries is the read mux
    assign sel_chain[g+1] = sel_chain[g] | (match[g] ? dat_r : '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tag_r <= '1;
      else if (inval) tag_r <= '1;
      else if (fill)  tag_r <= wr_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dat_r <= '0;
      else if (fill) dat_r <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (inval)  ptr_q <= '0;
    else if (wr_en)  ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign lk_hit  = |match;
  assign lk_data = sel_chain[NE];
endmodule

// File: rtl/vtx_reuse_cache.sv
module vtx_reuse_cache
  import vc_pkg::*;
#(
  parameter int VW = 16,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int NE = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_indexed,
  input  logic          cfg_wide,
  input  logic [CW-1:0] cfg_count,
  input  logic [VW-1:0] cfg_offset,
  output logic          idx_rd_en,
  output logic [VW-1:0] idx_rd_addr,
  input  logic [VW-1:0] idx_rd_data,
  output logic          shd_req_valid,
  input  logic          shd_req_ready,
  output logic [VW-1:0] shd_req_vid,
  input  logic          shd_rsp_valid,
  output logic          shd_rsp_ready,
  input  logic [DW-1:0] shd_rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_vid,
  output logic [DW-1:0] out_data,
  output logic          out_hit,
  output logic          done,
  output logic          err
);
  localparam logic [VW-1:0] BAD_VID = '1;

  vc_state_e     state_q;
  logic          mode_idx_q, wide_q, hit_q, illegal_q, done_q, err_q;
  logic [CW-1:0] count_q, pos_q, rd_pos;
  logic [VW-1:0] offset_q, vid_q, vid_c;
  logic [DW-1:0] data_q, lk_data;
  logic          lk_en, lk_hit, wr_en, last_pos, out_fire, illegal_c;

  assign last_pos  = (pos_q == count_q - 1'b1);
  assign out_fire  = (state_q == ST_EMIT) && out_ready;
  assign rd_pos    = (state_q == ST_EMIT) ? pos_q + 1'b1 : pos_q;
  assign illegal_c = mode_idx_q && (vid_c == BAD_VID);
  assign lk_en     = (state_q == ST_LOOK) && mode_idx_q && !illegal_c;
  assign wr_en     = (state_q == ST_RSP) && shd_rsp_valid && mode_idx_q && !illegal_q;
  // next index fetch overlaps the handshake of the current beat
  assign idx_rd_en = mode_idx_q && ((state_q == ST_FETCH) || (out_fire && !last_pos));

  vc_index_sel #(.VW(VW), .CW(CW)) u_isel (
    .indexed (mode_idx_q),
    .wide    (wide_q),
    .rd_pos  (rd_pos),
    .cur_pos (pos_q),
    .offset  (offset_q),
    .rd_data (idx_rd_data),
    .rd_addr (idx_rd_addr),
    .vid     (vid_c)
  );

  vc_tag_store #(.NE(NE), .VW(VW), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .inval   ((state_q == ST_IDLE) && start),
    .lk_en   (lk_en),
    .lk_key  (vid_c),
    .wr_en   (wr_en),
    .wr_tag  (vid_q),
    .wr_data (shd_rsp_data),
    .lk_hit  (lk_hit),
    .lk_data (lk_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_idx_q <= 1'b0;
      wide_q     <= 1'b0;
      count_q    <= '0;
      offset_q   <= '0;
      pos_q      <= '0;
      vid_q      <= '0;
      data_q     <= '0;
      hit_q      <= 1'b0;
      illegal_q  <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_idx_q <= cfg_indexed;
            wide_q     <= cfg_wide;
            count_q    <= cfg_count;
            offset_q   <= cfg_offset;
            pos_q      <= '0;
            if (cfg_count == '0) done_q  <= 1'b1;
            else                 state_q <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_LOOK;
        ST_LOOK: begin
          vid_q     <= vid_c;
          illegal_q <= illegal_c;
          hit_q     <= lk_hit;
          if (illegal_c) err_q <= 1'b1;
          if (lk_hit) begin
            data_q  <= lk_data;
            state_q <= ST_EMIT;
          end else begin
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (shd_req_ready) state_q <= ST_RSP;
        ST_RSP: begin
          if (shd_rsp_valid) begin
            data_q  <= shd_rsp_data;
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (last_pos) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              pos_q   <= pos_q + 1'b1;
              state_q <= ST_LOOK;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign shd_req_valid = (state_q == ST_REQ);
  assign shd_req_vid   = vid_q;
  assign shd_rsp_ready = (state_q == ST_RSP);
  assign out_valid     = (state_q == ST_EMIT);
  assign out_vid       = vid_q;
  assign out_data      = data_q;
  assign out_hit       = hit_q;
  assign done          = done_q;
  assign err           = err_q;
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int VW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VW-1:0] out_vid,
  input logic [DW-1:0] out_data,
  input logic          out_hit,
  input logic          shd_req_valid,
  input logic          shd_req_ready,
  input logic [VW-1:0] shd_req_vid,
  input logic          idx_rd_en,
  input logic          err,
  input logic          done,
  input logic          mode_idx_q
);
  // R1: quiet interface while held in reset
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!out_valid && !shd_req_valid && !idx_rd_en)
        else $error("R1 outputs active in reset");
    end
  end

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vid) && $stable(out_data) && $stable(out_hit)));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_req_valid && !shd_req_ready) |=> (shd_req_valid && $stable(shd_req_vid)));

  assert_hit_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (out_vid != '1));

  assert_linear_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_idx_q |-> (!idx_rd_en && !err && !(out_valid && out_hit)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind vtx_reuse_cache vc_checker #(.VW(VW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_vid       (out_vid),
  .out_data      (out_data),
  .out_hit       (out_hit),
  .shd_req_valid (shd_req_valid),
  .shd_req_ready (shd_req_ready),
  .shd_req_vid   (shd_req_vid),
  .idx_rd_en     (idx_rd_en),
  .err           (err),
  .done          (done),
  .mode_idx_q    (mode_idx_q)
);

// File: tb/sim_vtx_reuse_cache.sv
module sim_vtx_reuse_cache;
  localparam int VW = 16, DW = 32, CW = 16, NE = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0, cfg_indexed = 1'b0, cfg_wide = 1'b0;
  logic [CW-1:0] cfg_count = '0;
  logic [VW-1:0] cfg_offset = '0;
  logic          idx_rd_en;
  logic [VW-1:0] idx_rd_addr;
  logic [VW-1:0] idx_rd_data = '0;
  logic          shd_req_valid, shd_req_ready = 1'b0;
  logic [VW-1:0] shd_req_vid;
  logic          shd_rsp_valid = 1'b0, shd_rsp_ready;
  logic [DW-1:0] shd_rsp_data = '0;
  logic          out_valid, out_ready = 1'b0, out_hit, done, err;
  logic [VW-1:0] out_vid;
  logic [DW-1:0] out_data;

  vtx_reuse_cache #(.VW(VW), .DW(DW), .CW(CW), .NE(NE)) u0 (.*);

  // index memory: synchronous read
  logic [15:0] mem [0:255];
  always_ff @(posedge clk) if (idx_rd_en) idx_rd_data <= mem[idx_rd_addr[7:0]];

  int checks = 0, errors = 0;
  int nc = 0, shade_cnt = 0, ngot = 0, ndone = 0, nerr = 0;
  int done_nc = 0, last_nc = 0, start_nc = 0, lat = 0;
  logic bp_on = 1'b0, pend = 1'b0, rsp_fire = 1'b0;
  logic [15:0] pend_vid = '0;
  logic [15:0] got_vid [0:127];
  logic [31:0] got_data [0:127];
  logic        got_hit [0:127];

  // shader and consumer models, acting between clock edges
  always @(negedge clk) begin
    nc++;
    if (rsp_fire) begin shd_rsp_valid = 1'b0; rsp_fire = 1'b0; end
    if (pend) begin
      if (lat > 0) lat--;
      else begin
        shd_rsp_valid = 1'b1;
        shd_rsp_data  = {shade_cnt[15:0], pend_vid};
        shade_cnt++;
        pend = 1'b0;
      end
    end
    shd_req_ready = bp_on ? (nc % 3 != 1) : 1'b1;
    out_ready     = bp_on ? (nc % 3 != 0) : 1'b1;
    if (shd_rsp_valid && shd_rsp_ready) rsp_fire = 1'b1;
    if (shd_req_valid && shd_req_ready) begin pend = 1'b1; lat = 2; pend_vid = shd_req_vid; end
    if (out_valid && out_ready && ngot < 128) begin
      got_vid[ngot] = out_vid; got_data[ngot] = out_data; got_hit[ngot] = out_hit;
      ngot++; last_nc = nc;
    end
    if (done) begin ndone++; done_nc = nc; end
    if (err) nerr++;
    if (start) start_nc = nc;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat_val(input int pat, input int p);
    case (pat)
      0: return 16'(p % 4);
      2: return 16'(p % 34);
      3: return 16'(300 + (p * 7) % 5);
      4: return 16'(250 + p % 6);
      5: return (p % 2 == 1) ? 16'hFFFF : 16'd5;
      6: return (p < 33) ? 16'(p) : (p == 33) ? 16'd32 : (p == 34) ? 16'd1 : 16'd0;
      default: return 16'(p);
    endcase
  endfunction

  // fields: [31] indexed, [30] wide, [29:27] pattern, [26] back-pressure, [23:16] count, [15:0] offset
  localparam logic [31:0] TBL [0:8] = '{
    {1'b0, 1'b0, 3'd0, 1'b0, 2'b00, 8'd10, 16'd100},
    {1'b1, 1'b1, 3'd0, 1'b0, 2'b00, 8'd12, 16'd0},
    {1'b1, 1'b0, 3'd4, 1'b1, 2'b00, 8'd14, 16'd0},
    {1'b1, 1'b1, 3'd2, 1'b0, 2'b00, 8'd68, 16'd0},
    {1'b1, 1'b1, 3'd3, 1'b1, 2'b00, 8'd20, 16'd0},
    {1'b0, 1'b0, 3'd0, 1'b1, 2'b00, 8'd5, 16'hFFFD},
    {1'b1, 1'b1, 3'd0, 1'b1, 2'b00, 8'd12, 16'd0},
    {1'b1, 1'b1, 3'd5, 1'b0, 2'b00, 8'd6, 16'd0},
    {1'b1, 1'b1, 3'd0, 1'b0, 2'b00, 8'd0, 16'd0}
  };

  task automatic run_draw(input logic [31:0] ent);
    logic idxm, wd;
    int pat, cnt, mptr, k, experr, sh0, tmo;
    logic [15:0] off, v, vid;
    logic [15:0] mtag [NE];
    logic [31:0] mdat [NE];
    logic [31:0] edata;
    bit hit;
    string tg;
    idxm = ent[31]; wd = ent[30]; pat = int'(ent[29:27]); cnt = int'(ent[23:16]); off = ent[15:0];
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int p = 0; p < cnt; p++) begin
      v = pat_val(pat, p);
      if (wd) mem[p] = v;
      else if (p % 2 == 1) mem[p/2][15:8] = v[7:0];
      else mem[p/2][7:0] = v[7:0];
    end
    bp_on = ent[26]; ngot = 0; ndone = 0; nerr = 0;
    sh0 = shade_cnt;
    @(posedge clk); #1;
    cfg_indexed = idxm; cfg_wide = wd; cfg_count = CW'(cnt); cfg_offset = off; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    tmo = 0;
    while (ndone == 0 && tmo < 5000) begin @(negedge clk); tmo++; end
    chk(ndone == 1, "R9 done seen", 64'(ndone), 64'd1);
    repeat (3) @(negedge clk);
    // reference built from the requirements
    for (int i = 0; i < NE; i++) begin mtag[i] = 16'hFFFF; mdat[i] = '0; end
    mptr = 0; k = 0; experr = 0;
    for (int p = 0; p < cnt; p++) begin
      v = pat_val(pat, p);
      vid = !idxm ? 16'(off + 16'(p)) : (wd ? v : {8'h00, v[7:0]});
      hit = 1'b0; edata = '0;
      if (idxm && vid != 16'hFFFF)
        for (int i = 0; i < NE; i++) if (mtag[i] == vid) begin hit = 1'b1; edata = mdat[i]; end
      if (!hit) begin
        edata = {16'(sh0 + k), vid}; k++;
        if (idxm && vid != 16'hFFFF) begin mtag[mptr] = vid; mdat[mptr] = edata; mptr = (mptr + 1) % NE; end
      end
      if (idxm && vid == 16'hFFFF) experr++;
      tg = !idxm ? "R3" : (vid == 16'hFFFF) ? "R7" : hit ? "R5" : "R6";
      if (p < ngot) begin
        chk(got_vid[p] == vid, idxm ? "R4 vertex number" : "R3 vertex number", 64'(got_vid[p]), 64'(vid));
        chk(got_data[p] == edata && got_hit[p] == hit, tg, {got_hit[p], got_data[p]}, {hit, edata});
      end
    end
    chk(ngot == cnt, "R8 beat count", 64'(ngot), 64'(cnt));
    chk(shade_cnt - sh0 == k, "R5 R6 shader requests", 64'(shade_cnt - sh0), 64'(k));
    chk(nerr == experr, "R7 error pulses", 64'(nerr), 64'(experr));
    if (cnt > 0) chk(done_nc == last_nc + 1, "R9 done timing", 64'(done_nc), 64'(last_nc + 1));
    else         chk(done_nc == start_nc + 1, "R9 empty draw", 64'(done_nc), 64'(start_nc + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !shd_req_valid && !idx_rd_en && !done && !err, "R1 in reset",
        {out_valid, shd_req_valid, idx_rd_en, done, err}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!out_valid && !shd_req_valid && !idx_rd_en && !done && !err, "R1 after reset",
        {out_valid, shd_req_valid, idx_rd_en, done, err}, 64'd0);

    for (int t = 0; t < 9; t++) run_draw(TBL[t]);

    // R2: repeated draw starts cold again
    run_draw(TBL[1]);
    chk(got_hit[0] == 1'b0, "R2 first vertex misses after start", 64'(got_hit[0]), 64'd0);
    chk(got_hit[4] == 1'b1, "R2 reuse inside one draw", 64'(got_hit[4]), 64'd1);

    // R6: pointer wrap keeps recent entries, evicts the oldest
    run_draw({1'b1, 1'b1, 3'd6, 1'b0, 2'b00, 8'd36, 16'd0});
    chk(got_hit[33] == 1'b1, "R6 newest after wrap hits", 64'(got_hit[33]), 64'd1);
    chk(got_hit[34] == 1'b1, "R6 second slot survives", 64'(got_hit[34]), 64'd1);
    chk(got_hit[35] == 1'b0, "R6 oldest evicted", 64'(got_hit[35]), 64'd0);

    // R7: illegal index repeated never hits
    run_draw(TBL[7]);
    chk(got_hit[3] == 1'b0 && got_vid[3] == 16'hFFFF, "R7 no hit on 0xFFFF",
        {got_hit[3], got_vid[3]}, {1'b0, 16'hFFFF});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule